// File: doc/BRIEF.md
# Serial Receive Shifter with Break Detection

This block turns an asynchronous serial line into bytes. A 16x oversampling tick from an external divider paces it. The line passes through a two-flop synchroniser. A falling edge is confirmed half a bit later, and each following bit is then sampled once per bit time at its centre. Data arrives least significant bit first, followed by an optional parity bit and one stop bit.

Each finished character appears on `data_o` together with three status flags: parity error, framing error and break. A strobe marks it for a single clock cycle. The data and flags keep their values until the next character is finished.

Two line conditions get special handling. A frame that is low from start to stop is reported once as a break, and the receiver then waits for the line to go high again. A low stop bit in an ordinary frame is taken as the start bit of the next character, so that character is received without waiting for a new falling edge.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset, `valid_o` is low and `data_o`, `perr_o`, `ferr_o` and `brk_o` are all zero.
- R2: A low level on the line counts as a start bit only if the line is still low 8 ticks after the falling edge. A shorter low pulse produces no character.
- R3: A character is reported with exactly one `valid_o` pulse. `data_o` holds the 8 data bits, and the bit received first is in bit 0.
- R4: When `par_en_i` is 1, one parity bit follows the data. With `par_odd_i` = 0 the expected bit is the XOR of the data bits; with `par_odd_i` = 1 it is the inverse of that XOR. `perr_o` is 1 when the received bit differs from the expected one. When `par_en_i` is 0, no parity bit is received and `perr_o` is 0.
- R5: `ferr_o` is 1 exactly when the sampled stop bit is 0.
- R6: After a framing error that is not a break, the low stop-bit sample serves as the start bit of the next character. The next data bit is sampled 16 ticks later.
- R7: A frame in which every sample is 0 (start, data, parity if enabled, and stop) is reported as a break. The character has `data_o` = 0, `brk_o` = 1, `ferr_o` = 1 and `perr_o` = 0.
- R8: After a break, exactly one character is reported however long the line stays low. Reception starts again only after the line has been sampled high.
- R9: `valid_o` is never high for two cycles in a row. It rises only in the cycle after a sample tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| rxd_i | input | 1 | Serial input line, idle high |
| par_en_i | input | 1 | 1: a parity bit follows the data |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| valid_o | output | 1 | One-cycle strobe for a finished character |
| data_o | output | 8 | Received data byte |
| perr_o | output | 1 | Parity error for the character |
| ferr_o | output | 1 | Framing error for the character |
| brk_o | output | 1 | Break condition for the character |

## Verification
The assertions check on every cycle that the strobe lasts one cycle and follows a sample tick. They also check that a break always carries the framing flag, a zero byte and no parity error.

Other behaviours depend on what the line did over a whole frame, so only the bench's scenarios can show them. These are the data and parity values over a full byte sweep in each parity mode, and the rejection of short glitches. They also include the early-start resynchronisation after a bad stop bit and the single report during a long break.

// File: rtl/uart_brk_rx_pkg.sv
package uart_brk_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic perr;
        logic ferr;
        logic brk;
    } rx_flags_t;

endpackage

// File: rtl/uart_brk_rx_sync.sv
module uart_brk_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_brk_rx_parity.sv
module uart_brk_rx_parity #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic             odd_i,
    output logic             exp_o
);
    // expected parity bit: makes the total count of ones even (or odd)
    assign exp_o = (^data_i) ^ odd_i;
endmodule

// File: rtl/uart_brk_rx_fsm.sv
module uart_brk_rx_fsm
    import uart_brk_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic                 rx_i,
    input  logic                 par_en_i,
    input  logic                 exp_par_i,
    output logic [DATA_BITS-1:0] shift_o,
    output logic                 valid_o,
    output logic [DATA_BITS-1:0] data_o,
    output rx_flags_t            flags_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e            state;
        logic [CNT_W-1:0]     cnt;
        logic [BIT_W-1:0]     bidx;
        logic [DATA_BITS-1:0] shift;
        logic                 par_bit;
        logic                 zeros;
        logic                 prev;
        logic                 valid;
        logic [DATA_BITS-1:0] data;
        rx_flags_t            flags;
    } fsm_t;

    fsm_t st_d, st_q;
    logic brk_now;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        brk_now    = st_q.zeros & ~rx_i;
        if (tick_i) begin
            unique case (st_q.state)
                ST_IDLE: begin
                    st_d.prev = rx_i;
                    if (st_q.prev && !rx_i) begin
                        st_d.state = ST_START;
                        st_d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (st_q.cnt == MID_CNT) begin
                        st_d.cnt = '0;
                        if (!rx_i) begin
                            st_d.state = ST_DATA;
                            st_d.bidx  = '0;
                            st_d.zeros = 1'b1;
                        end else begin
                            st_d.state = ST_IDLE;
                            st_d.prev  = 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (st_q.cnt == LAST_CNT) begin
                        st_d.cnt   = '0;
                        st_d.shift = {rx_i, st_q.shift[DATA_BITS-1:1]};
                        st_d.zeros = st_q.zeros & ~rx_i;
                        if (st_q.bidx == LAST_BIT) begin
                            st_d.state = par_en_i ? ST_PAR : ST_STOP;
                        end else begin
                            st_d.bidx = st_q.bidx + 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (st_q.cnt == LAST_CNT) begin
                        st_d.cnt     = '0;
                        st_d.par_bit = rx_i;
                        st_d.zeros   = st_q.zeros & ~rx_i;
                        st_d.state   = ST_STOP;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (st_q.cnt == LAST_CNT) begin
                        st_d.cnt        = '0;
                        st_d.valid      = 1'b1;
                        st_d.data       = st_q.shift;
                        st_d.flags.ferr = ~rx_i;
                        st_d.flags.brk  = brk_now;
                        st_d.flags.perr = par_en_i & ~brk_now
                                          & (st_q.par_bit ^ exp_par_i);
                        if (brk_now) begin
                            st_d.state = ST_BRKWAIT;
                        end else if (!rx_i) begin
                            // low stop sample doubles as the next start bit
                            st_d.state = ST_DATA;
                            st_d.bidx  = '0;
                            st_d.zeros = 1'b1;
                        end else begin
                            st_d.state = ST_IDLE;
                            st_d.prev  = 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                ST_BRKWAIT: begin
                    if (rx_i) begin
                        st_d.state = ST_IDLE;
                        st_d.prev  = 1'b1;
                    end
                end
                default: st_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q         <= '0;
            st_q.state   <= ST_IDLE;
            st_q.prev    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_o = st_q.shift;
    assign valid_o = st_q.valid;
    assign data_o  = st_q.data;
    assign flags_o = st_q.flags;
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
    import uart_brk_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic                 rxd_i,
    input  logic                 par_en_i,
    input  logic                 par_odd_i,
    output logic                 valid_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 perr_o,
    output logic                 ferr_o,
    output logic                 brk_o
);
    logic                 rx_s;
    logic                 exp_par;
    logic [DATA_BITS-1:0] shift;
    rx_flags_t            flags;

    uart_brk_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rxd_i),
        .q_o    (rx_s)
    );

    uart_brk_rx_parity #(.WIDTH(DATA_BITS)) u_par (
        .data_i (shift),
        .odd_i  (par_odd_i),
        .exp_o  (exp_par)
    );

    uart_brk_rx_fsm #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .rx_i      (rx_s),
        .par_en_i  (par_en_i),
        .exp_par_i (exp_par),
        .shift_o   (shift),
        .valid_o   (valid_o),
        .data_o    (data_o),
        .flags_o   (flags)
    );

    assign perr_o = flags.perr;
    assign ferr_o = flags.ferr;
    assign brk_o  = flags.brk;
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 tick_i,
    input logic                 valid_o,
    input logic [DATA_BITS-1:0] data_o,
    input logic                 perr_o,
    input logic                 ferr_o,
    input logic                 brk_o
);
    assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    assert_strobe_after_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(valid_o) |-> $past(tick_i));

    assert_break_framing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_o |-> (ferr_o && data_o == '0));

    assert_break_no_parity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_o |-> !perr_o);

    assert_hold_between_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> $stable(data_o));
endmodule

bind uart_brk_rx uart_brk_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .valid_o (valid_o),
    .data_o  (data_o),
    .perr_o  (perr_o),
    .ferr_o  (ferr_o),
    .brk_o   (brk_o)
);

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb;
    localparam int BIT = 32;  // 16 ticks, one tick every 2 cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       valid;
    logic [7:0] data;
    logic       perr, ferr, brk;

    int checks = 0;
    int errors = 0;
    int got_n  = 0;
    logic [7:0] got_d [0:1023];
    logic [2:0] got_f [0:1023];  // {perr, ferr, brk}

    always #2 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;

    uart_brk_rx u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .rxd_i     (rxd),
        .par_en_i  (par_en),
        .par_odd_i (par_odd),
        .valid_o   (valid),
        .data_o    (data),
        .perr_o    (perr),
        .ferr_o    (ferr),
        .brk_o     (brk)
    );

    always @(negedge clk)
        if (rst_n && valid) begin
            got_d[got_n % 1024] = data;
            got_f[got_n % 1024] = {perr, ferr, brk};
            got_n = got_n + 1;
        end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int cycles);
        @(negedge clk) rxd = v;
        repeat (cycles - 1) @(negedge clk);
    endtask

    task automatic send_body(input logic [7:0] d, input bit flip, input logic stop_v);
        for (int i = 0; i < 8; i++) drive(d[i], BIT);
        if (par_en) drive((^d) ^ par_odd ^ flip, BIT);
        drive(stop_v, BIT);
    endtask

    task automatic send(input logic [7:0] d, input bit flip);
        drive(1'b0, BIT);
        send_body(d, flip, 1'b1);
        drive(1'b1, BIT);
    endtask

    task automatic expect_one(input int base, input logic [7:0] d, input logic [2:0] f,
                              input string req);
        chk(got_n == base + 1, req, got_n - base, 1);
        chk(got_d[base % 1024] == d, req, got_d[base % 1024], d);
        chk(got_f[base % 1024] == f, req, got_f[base % 1024], f);
    endtask

    initial begin
        int base;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk({valid, data, perr, ferr, brk} == '0, "R1", {valid, data, perr, ferr, brk}, 0);
        rst_n = 1'b1;
        drive(1'b1, 3 * BIT);
        chk(valid == 1'b0 && got_n == 0, "R1", got_n, 0);

        // R3 R4: full sweep, even parity
        par_en = 1'b1; par_odd = 1'b0;
        for (int b = 0; b < 256; b++) begin
            base = got_n;
            send(8'(b), 1'b0);
            expect_one(base, 8'(b), 3'b000, "R3");
        end

        // R4: odd parity, good and corrupted parity bits
        par_odd = 1'b1;
        for (int b = 0; b < 32; b++) begin
            base = got_n;
            send(8'(b * 7 + 3), 1'b0);
            expect_one(base, 8'(b * 7 + 3), 3'b000, "R4");
            base = got_n;
            send(8'(b * 11 + 1), 1'b1);
            expect_one(base, 8'(b * 11 + 1), 3'b100, "R4");
        end

        // R4: no parity bit
        par_en = 1'b0;
        for (int b = 0; b < 32; b++) begin
            base = got_n;
            send(8'(b * 13 + 5), 1'b0);
            expect_one(base, 8'(b * 13 + 5), 3'b000, "R4");
        end

        // R2: short glitch is not a start bit
        base = got_n;
        drive(1'b0, 8);
        drive(1'b1, 12 * BIT);
        chk(got_n == base, "R2", got_n - base, 0);

        // R5 R6: low stop bit then next byte with no new edge
        par_en = 1'b1; par_odd = 1'b0;
        base = got_n;
        drive(1'b0, BIT);
        send_body(8'h5A, 1'b0, 1'b0);
        send_body(8'hC3, 1'b0, 1'b1);
        drive(1'b1, BIT);
        chk(got_n == base + 2, "R6", got_n - base, 2);
        chk(got_d[base % 1024] == 8'h5A && got_f[base % 1024] == 3'b010, "R5",
            {got_d[base % 1024], got_f[base % 1024]}, {8'h5A, 3'b010});
        chk(got_d[(base + 1) % 1024] == 8'hC3 && got_f[(base + 1) % 1024] == 3'b000, "R6",
            {got_d[(base + 1) % 1024], got_f[(base + 1) % 1024]}, {8'hC3, 3'b000});

        // R7 R8: long break with odd parity, then a normal byte
        par_odd = 1'b1;
        base = got_n;
        drive(1'b0, 44 * BIT);
        chk(got_n == base + 1, "R8", got_n - base, 1);
        chk(got_d[base % 1024] == 8'h00 && got_f[base % 1024] == 3'b011, "R7",
            {got_d[base % 1024], got_f[base % 1024]}, {8'h00, 3'b011});
        drive(1'b1, 2 * BIT);
        chk(got_n == base + 1, "R8", got_n - base, 1);
        base = got_n;
        send(8'h3C, 1'b0);
        expect_one(base, 8'h3C, 3'b000, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule